// File: doc/BRIEF.md
# Windowed Per-Peripheral Clock Settings Register

This block exposes a whole table of per-peripheral clock settings through one bus register. Software first writes the register with its command bit clear. That write only names a peripheral. A read of the same register then returns the named peripheral's stored settings. A write with the command bit set both names a peripheral and loads new settings into that peripheral's table entry.

Each entry holds five settings for one peripheral:
- the peripheral clock enable,
- a two-bit prescaler code,
- a three-bit source choice for the generated clock,
- an eight-bit divisor for the generated clock,
- the generated-clock enable.

The settings of every entry are driven at all times on flat output vectors, so that the clock dividers and gates next to the block can use them. Slot `i` of each vector belongs to peripheral `i`.

The bus side is a simple one-cycle strobe interface. A read strobe loads a registered read-data port. That port then holds its value until the next read strobe.

Top module: `pcr_ctrl`

## Requirements
- R1: After a synchronous reset, every entry is zero (both clock enables off, prescaler code 0, source 0, divisor 0), the selected ID is 0, and the read-data port is 0.
- R2: A write to the register address with bit 12 clear latches bits [5:0] as the selected ID. It changes no table entry and no per-peripheral output.
- R3: A read strobe at the register address loads the read-data port on that same clock edge. The loaded word has these fields, and every other bit, bit 12 included, reads as zero:
  - the selected ID in [5:0],
  - the selected entry's source in [10:8],
  - the prescaler code in [17:16],
  - the divisor in [27:20],
  - the peripheral clock enable in bit 28,
  - the generated-clock enable in bit 29.
- R4: A write to the register address with bit 12 set stores the word's fields into the entry named by bits [5:0]. The field positions are those listed in R3. The entry's outputs show the new values right after the clock edge that accepts the write.
- R5: A write with bit 12 set that names an ID below 2 (or one at or above the table size) leaves every entry unchanged.
- R6: Writes to any other address change neither the selected ID nor the table. A read strobe at any other address loads zero into the read-data port.
- R7: A command write leaves every entry other than the named one unchanged.
- R8: A command write also selects its ID. A read that follows it directly, with no select-only write in between, returns the entry just written.
- R9: Without a read strobe, the read-data port keeps its last value, even across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (12) | Byte address; the register sits at REG_OFFSET (0x10C) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pclk_en_o | output | NUM_PERIPH | Peripheral clock enable, one bit per ID |
| presc_o | output | 2*NUM_PERIPH | Prescaler code per ID (0:/1, 1:/2, 2:/4, 3:/8) |
| gsrc_o | output | 3*NUM_PERIPH | Generated-clock source choice per ID |
| gdiv_o | output | 8*NUM_PERIPH | Generated-clock divisor field per ID |
| gclk_en_o | output | NUM_PERIPH | Generated-clock enable per ID |

## Verification
Every result of this block is due exactly one clock edge after the strobe that causes it:
- a command write changes the per-peripheral outputs on the edge that samples it,
- a select write moves the selected ID on that same edge,
- a read loads the read-data port on the edge that samples the read strobe.

The bench drives every strobe for one cycle from a falling edge. It then samples at the next falling edge, which is half a period after the one edge the result needs. After each write the bench compares all outputs, so a change in any slot other than the one named is caught in the same cycle. Each read sweep selects an ID and reads it in the following strobe cycle, and the expected word is built from a bench model that applies R4 and R5 arithmetically.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

  // Bit layout of the windowed register word. Software depends on these positions.
  localparam int ID_LSB   = 0;
  localparam int ID_W     = 6;
  localparam int SRC_LSB  = 8;
  localparam int SRC_W    = 3;
  localparam int CMD_BIT  = 12;
  localparam int PRE_LSB  = 16;
  localparam int PRE_W    = 2;
  localparam int GDIV_LSB = 20;
  localparam int GDIV_W   = 8;
  localparam int PEN_BIT  = 28;
  localparam int GEN_BIT  = 29;
  localparam int WORD_W   = 32;

  typedef struct packed {
    logic              gen_en;
    logic              pclk_en;
    logic [GDIV_W-1:0] gdiv;
    logic [PRE_W-1:0]  presc;
    logic [SRC_W-1:0]  gsrc;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  function automatic entry_t word_to_entry(input logic [WORD_W-1:0] w);
    entry_t e;
    e.gen_en  = w[GEN_BIT];
    e.pclk_en = w[PEN_BIT];
    e.gdiv    = w[GDIV_LSB +: GDIV_W];
    e.presc   = w[PRE_LSB +: PRE_W];
    e.gsrc    = w[SRC_LSB +: SRC_W];
    return e;
  endfunction

  function automatic logic [WORD_W-1:0] entry_to_word(input entry_t e,
                                                      input logic [ID_W-1:0] id);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ID_LSB +: ID_W]     = id;
    w[SRC_LSB +: SRC_W]   = e.gsrc;
    w[PRE_LSB +: PRE_W]   = e.presc;
    w[GDIV_LSB +: GDIV_W] = e.gdiv;
    w[PEN_BIT]            = e.pclk_en;
    w[GEN_BIT]            = e.gen_en;
    return w;
  endfunction

endpackage

// File: rtl/pcr_decode.sv
module pcr_decode
  import pcr_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h10C,
  parameter int                NUM_PERIPH = 64,
  parameter int                ID_MIN     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [ID_W-1:0]   sel_id,
  output logic              upd_en,
  output logic [ID_W-1:0]   upd_id,
  output entry_t            upd_data,
  output logic              rd_hit
);

  localparam logic [ID_W:0] ID_LO = ID_MIN[ID_W:0];
  localparam logic [ID_W:0] ID_HI = NUM_PERIPH[ID_W:0];

  logic            wr_hit;
  logic [ID_W-1:0] wid;
  logic            id_ok;
  logic            unused_bits;

  assign wr_hit = wr_en && (addr == REG_OFFSET);
  assign rd_hit = rd_en && (addr == REG_OFFSET);
  assign wid    = wdata[ID_LSB +: ID_W];
  assign id_ok  = ({1'b0, wid} >= ID_LO) && ({1'b0, wid} < ID_HI);

  assign upd_en   = wr_hit && wdata[CMD_BIT] && id_ok;
  assign upd_id   = wid;
  assign upd_data = word_to_entry(wdata);

  // Bits of the write word that carry no field.
  assign unused_bits = ^{wdata[31:30], wdata[19:18], wdata[15:13],
                         wdata[11], wdata[7:6]};

  always_ff @(posedge clk) begin
    if (rst)         sel_id <= '0;
    else if (wr_hit) sel_id <= wid;
  end

  // R2
  sel_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_OFFSET) |=> sel_id == $past(wdata[ID_LSB +: ID_W]));

  // R6
  sel_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == REG_OFFSET) |=> $stable(sel_id));

endmodule

// File: rtl/pcr_entry.sv
module pcr_entry
  import pcr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   we,
  input  entry_t d,
  output entry_t q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end

  // R4
  entry_load_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> q == $past(d));

  // R7
  entry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));

endmodule

// File: rtl/pcr_readback.sv
module pcr_readback
  import pcr_pkg::*;
#(
  parameter int NUM_PERIPH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              rd_hit,
  input  logic [ID_W-1:0]   sel_id,
  input  entry_t            tbl [NUM_PERIPH],
  output logic [WORD_W-1:0] rdata
);

  entry_t pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_PERIPH; i++) begin
      if (sel_id == ID_W'(i)) pick = tbl[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_hit ? entry_to_word(pick, sel_id) : '0;
  end

  // R3
  rd_id_chk: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> rdata[ID_LSB +: ID_W] == $past(sel_id));

  // R3
  rd_cmd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rdata[CMD_BIT] == 1'b0);

  // R6
  rd_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_hit) |=> rdata == '0);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/pcr_ctrl.sv
module pcr_ctrl
  import pcr_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h10C,
  parameter int                NUM_PERIPH = 64,
  parameter int                ID_MIN     = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  output logic [NUM_PERIPH-1:0]        pclk_en_o,
  output logic [2*NUM_PERIPH-1:0]      presc_o,
  output logic [3*NUM_PERIPH-1:0]      gsrc_o,
  output logic [8*NUM_PERIPH-1:0]      gdiv_o,
  output logic [NUM_PERIPH-1:0]        gclk_en_o
);

  logic [ID_W-1:0] sel_id;
  logic            upd_en;
  logic [ID_W-1:0] upd_id;
  entry_t          upd_data;
  logic            rd_hit;
  entry_t          tbl [NUM_PERIPH];

  pcr_decode #(
    .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET),
    .NUM_PERIPH(NUM_PERIPH), .ID_MIN(ID_MIN)
  ) dec_i (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .sel_id(sel_id),
    .upd_en(upd_en), .upd_id(upd_id), .upd_data(upd_data), .rd_hit(rd_hit)
  );

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_slot
    if (i >= ID_MIN) begin : g_live
      logic we;
      assign we = upd_en && (upd_id == ID_W'(i));
      pcr_entry ent_i (
        .clk(clk), .rst(rst), .we(we), .d(upd_data), .q(tbl[i])
      );
    end else begin : g_reserved
      assign tbl[i] = '0;
    end
    assign pclk_en_o[i]            = tbl[i].pclk_en;
    assign presc_o[2*i +: 2]       = tbl[i].presc;
    assign gsrc_o[3*i +: 3]        = tbl[i].gsrc;
    assign gdiv_o[8*i +: 8]        = tbl[i].gdiv;
    assign gclk_en_o[i]            = tbl[i].gen_en;
  end

  pcr_readback #(.NUM_PERIPH(NUM_PERIPH)) rb_i (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .rd_hit(rd_hit),
    .sel_id(sel_id), .tbl(tbl), .rdata(bus_rdata)
  );

endmodule

// File: tb/pcr_ctrl_tb.sv
module pcr_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 64;
  localparam logic [11:0] REG_ADDR = 12'h10C;
  localparam logic [31:0] FMASK    = 32'h3FF3_0700;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0]   pclk_en_o;
  logic [2*NP-1:0] presc_o;
  logic [3*NP-1:0] gsrc_o;
  logic [8*NP-1:0] gdiv_o;
  logic [NP-1:0]   gclk_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  pcr_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pclk_en_o(pclk_en_o), .presc_o(presc_o), .gsrc_o(gsrc_o),
    .gdiv_o(gdiv_o), .gclk_en_o(gclk_en_o)
  );

  task automatic chk(input string req, input logic [1023:0] act, input logic [1023:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Compare every output slot against the model.
  task automatic chk_outputs(input string req);
    logic [NP-1:0]   e_pen, e_gen;
    logic [2*NP-1:0] e_pre;
    logic [3*NP-1:0] e_src;
    logic [8*NP-1:0] e_div;
    for (int i = 0; i < NP; i++) begin
      e_pen[i]       = model[i][28];
      e_gen[i]       = model[i][29];
      e_pre[2*i +: 2] = model[i][17:16];
      e_src[3*i +: 3] = model[i][10:8];
      e_div[8*i +: 8] = model[i][27:20];
    end
    chk({req, " pclk_en"}, 1024'(pclk_en_o), 1024'(e_pen));
    chk({req, " presc"},   1024'(presc_o),   1024'(e_pre));
    chk({req, " gsrc"},    1024'(gsrc_o),    1024'(e_src));
    chk({req, " gdiv"},    1024'(gdiv_o),    1024'(e_div));
    chk({req, " gclk_en"}, 1024'(gclk_en_o), 1024'(e_gen));
  endtask

  function automatic logic [31:0] pattern(input int id, input logic [31:0] seed);
    logic [31:0] w;
    w = 32'(id) * 32'h9E37_79B1 + seed;
    w = (w & ~32'h0000_103F) | 32'h0000_1000 | 32'(id);
    return w;
  endfunction

  // Apply a command write to the bench model (R4, R5).
  task automatic cmd_write(input int id, input logic [31:0] w, input string req);
    bus_write(REG_ADDR, w);
    if (id >= 2) model[id] = w & FMASK;
    chk_outputs(req);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    chk_outputs("R1 reset");
    chk("R1 rdata reset", 1024'(bus_rdata), 1024'(0));
    bus_read(REG_ADDR);
    chk("R1 reset readback id0", 1024'(bus_rdata), 1024'(0));

    // R2: select only, fields present but no command
    bus_write(REG_ADDR, 32'h3FF3_0705);
    chk_outputs("R2 select only");
    bus_read(REG_ADDR);
    chk("R2 select readback", 1024'(bus_rdata), 1024'(32'h5));

    // R4 R5 R7: command writes to every ID
    for (int id = 0; id < NP; id++)
      cmd_write(id, pattern(id, 32'h1234_5678), (id < 2) ? "R5 low id" : "R4 R7 sweep A");

    // R3: select then read every ID
    for (int id = 0; id < NP; id++) begin
      bus_write(REG_ADDR, 32'(id));
      bus_read(REG_ADDR);
      chk("R3 readback sweep", 1024'(bus_rdata), 1024'(model[id] | 32'(id)));
    end

    // R8: command write then direct read
    cmd_write(17, pattern(17, 32'hCAFE_0001), "R4 rewrite");
    bus_read(REG_ADDR);
    chk("R8 read after cmd", 1024'(bus_rdata), 1024'(model[17] | 32'd17));

    // R6: other addresses
    bus_write(12'h108, 32'hFFFF_F000 | 32'd30);
    chk_outputs("R6 foreign write");
    bus_read(REG_ADDR);
    chk("R6 id kept", 1024'(bus_rdata), 1024'(model[17] | 32'd17));
    bus_read(12'h110);
    chk("R6 foreign read", 1024'(bus_rdata), 1024'(0));

    // R9: hold without read strobe
    bus_read(REG_ADDR);
    bus_write(REG_ADDR, 32'd40);
    cmd_write(40, pattern(40, 32'h0BAD_F00D), "R4 hold setup");
    repeat (3) @(negedge clk);
    chk("R9 rdata hold", 1024'(bus_rdata), 1024'(model[17] | 32'd17));

    // Sweep B in descending order with a new pattern
    for (int id = NP - 1; id >= 0; id--)
      cmd_write(id, pattern(id, 32'h7777_0F0F), (id < 2) ? "R5 low id B" : "R4 R7 sweep B");
    for (int id = 0; id < NP; id += 5) begin
      bus_write(REG_ADDR, 32'(id));
      bus_read(REG_ADDR);
      chk("R3 readback sweep B", 1024'(bus_rdata), 1024'(model[id] | 32'(id)));
    end

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule